// File: doc/BRIEF.md
# Serial Display Command and Readback Port

This block is the host-facing serial port of a vacuum-fluorescent display controller. A host talks to it over three wires: an active-high select, a serial clock and one shared data line. While the select is high, the port takes in one bit on each rising serial-clock edge. The first bit received is the least significant. Every write frame ends with a 3-bit mode code, so frames of different lengths are all decoded from their final three bits. When the select falls, the port decodes the mode. It then loads one or all of three 27-bit segment latches or the 10-bit dimming register, or it issues a one-cycle keyscan-stop strobe.

Reads take two select cycles. In the first, the host sends a read mode code. When the select rises again, the port captures either the 29-bit key/encoder status word or the 48-bit packed A/D word. It then asserts its output enable and shifts the captured word out, one bit per rising serial-clock edge, until the select drops. The select, serial clock and data-in are taken as already synchronous to the system clock, and the port finds their edges by comparing each with its value one clock earlier.

Top module: `vfd_host_port`

## Requirements
- R1: After reset all three segment latches, the dimming register, the output enable, the serial output and the stop strobe are zero.
- R2: A data bit is taken only on a rising serial-clock edge seen while the select is high. Serial-clock edges while the select is low change no state.
- R3: The mode value is M0 + 2·M1 + 4·M2, where M0, M1 and M2 are the last three bits received before the select falls. A 30-bit frame sends S1..S27 and then the mode. Mode 0 copies S1..S27 into all three segment latches, with bit n-1 of each latch holding Sn.
- R4: Modes 1, 2 and 3 load S1..S27 into the grid 1, grid 2 or grid 3 latch only. The other two latches keep their contents.
- R5: Mode 4 takes a 13-bit frame, D1..D10 followed by the mode. It loads the dimming register with D1 as its least significant bit, and it leaves the segment latches untouched.
- R6: Mode 5 can be sent as three bits on their own. It produces a stop strobe lasting exactly one clock cycle and changes no latch.
- R7: Modes 6 and 7 change no latch and do not enable the output in the cycle that carries them. The next select-high cycle enables the output from the select's rising edge until it falls, and no input bits are taken while the output is enabled.
- R8: A mode-6 read returns the key word least significant bit first. The order is keys row 1 columns 1..5, then rows 2..5 in the same way, then the direction bit, then counter bits Q1..Q3, making 29 bits.
- R9: A mode-7 read returns 48 bits: channel 1 through channel 6, each 8 bits with the least significant bit first. Channel k occupies bits 8(k-1)..8k-1 of the A/D word.
- R10: The read word is captured at the select rising edge that opens the read cycle. Later changes on the key and A/D inputs do not alter the bits shifted out.
- R11: The first read bit is on the output before the first serial clock. Each rising serial-clock edge advances to the next bit, and bits beyond the word length read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csel | input | 1 | Host select, active high |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Enable for driving the shared data line |
| seg_grid1 | output | 27 | Segment latch for grid 1 |
| seg_grid2 | output | 27 | Segment latch for grid 2 |
| seg_grid3 | output | 27 | Segment latch for grid 3 |
| dim_level | output | 10 | Dimming duty register |
| key_word | input | 29 | Parallel key/encoder status to be read |
| adc_word | input | 48 | Parallel packed A/D results to be read |
| scan_stop | output | 1 | One-cycle keyscan-stop strobe |

## Verification
All eight mode codes are swept with several segment patterns: sparse, alternating, all-ones and arithmetically scrambled. After each frame every latch is compared, so that the one latch a mode may touch can be told apart from the ones it must leave alone. The key read is run once for each of the 29 one-hot words, which exposes any swapped or shifted position. The A/D read uses distinct per-channel values, which separates channel order from bit order within a channel. Each read changes the parallel inputs after capture, to confirm the captured word is the one read out. Serial clocks sent while the select is low, followed by an empty select pulse, show whether stray bits leaked into the decoded mode.

// File: rtl/vfd_port_pkg.sv
// Shared constants and the mode code type for the serial display port.
// The mode value is M0 + 2*M1 + 4*M2 of the trailing three frame bits.
package vfd_port_pkg;
    localparam int MODE_W = 3;
    localparam int GRIDS  = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_SEG_ALL = 3'd0,
        MD_SEG_G1  = 3'd1,
        MD_SEG_G2  = 3'd2,
        MD_SEG_G3  = 3'd3,
        MD_DIM     = 3'd4,
        MD_STOP    = 3'd5,
        MD_KEY_RD  = 3'd6,
        MD_ADC_RD  = 3'd7
    } port_mode_e;
endpackage

// File: rtl/vfd_rx_shift.sv
// Receive shift register. New bits enter at the top and older bits move
// toward bit 0, so the last bits received always sit in the top positions
// whatever the frame length. Assumes shift_en is a one-cycle qualified edge.
module vfd_rx_shift #(
    parameter int RX_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            din,
    output logic [RX_W-1:0] frame
);
    // Shift one bit in from the top on each qualified serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame <= '0;
        else if (shift_en)
            frame <= {din, frame[RX_W-1:1]};
    end
endmodule

// File: rtl/vfd_latch_bank.sv
// Mode decode and holding latches. On a load request it interprets the top
// MODE_W bits of the receive frame, writes the grid latches or the dimming
// register, raises a stop strobe, or flags a read request for the transmit
// side. Assumes load is a single-cycle select-release event.
module vfd_latch_bank
    import vfd_port_pkg::*;
#(
    parameter int SEG_W = 27,
    parameter int DIM_W = 10,
    parameter int RX_W  = SEG_W + MODE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [RX_W-1:0]            frame,
    output logic [GRIDS-1:0][SEG_W-1:0] grid_q,
    output logic [DIM_W-1:0]           dim_q,
    output logic                       stop_q,
    output logic                       rd_arm,
    output logic                       rd_adc
);
    port_mode_e mode;

    // Mode field is always the last three bits received.
    assign mode   = port_mode_e'(frame[RX_W-1 -: MODE_W]);
    // Read modes request a capture on the next select rise.
    assign rd_arm = load && (mode == MD_KEY_RD || mode == MD_ADC_RD);
    assign rd_adc = (mode == MD_ADC_RD);

    for (genvar g = 0; g < GRIDS; g++) begin : g_grid
        // Grid latch g loads on the broadcast mode or its own mode.
        always_ff @(posedge clk) begin
            if (!rst_n)
                grid_q[g] <= '0;
            else if (load && (mode == MD_SEG_ALL ||
                              mode == port_mode_e'(MODE_W'(g + 1))))
                grid_q[g] <= frame[SEG_W-1:0];
        end
    end

    // Dimming register takes the field just below the mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dim_q <= '0;
        else if (load && mode == MD_DIM)
            dim_q <= frame[SEG_W-1 -: DIM_W];
    end

    // Stop strobe lasts one cycle after a stop frame is released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_q <= 1'b0;
        else
            stop_q <= load && (mode == MD_STOP);
    end

    // R4: a single-grid write leaves the other grids alone.
    a_r4_single_grid: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode == MD_SEG_G1) |=> ($stable(grid_q[1]) && $stable(grid_q[2])));

    // R7: a read-mode frame writes no latch.
    a_r7_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (mode == MD_KEY_RD || mode == MD_ADC_RD))
            |=> ($stable(grid_q) && $stable(dim_q)));

    // R6: the stop strobe never lasts two cycles.
    a_r6_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> !stop_q);
endmodule

// File: rtl/vfd_tx_shift.sv
// Readback side. A read request arms it. The next select rise captures the
// chosen parallel word and enables the output, and each qualified serial
// edge then shifts one bit out from bit 0 with zeros filling behind.
// Assumes arm and cs_rise never coincide.
module vfd_tx_shift #(
    parameter int KEY_W = 29,
    parameter int ADC_W = 48,
    parameter int TX_W  = (KEY_W > ADC_W) ? KEY_W : ADC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             arm_adc,
    input  logic             cs_rise,
    input  logic             cs_fall,
    input  logic             shift_en,
    input  logic [KEY_W-1:0] key_word,
    input  logic [ADC_W-1:0] adc_word,
    output logic             sdo,
    output logic             oe
);
    logic            armed;
    logic            armed_adc;
    logic [TX_W-1:0] shreg;
    logic [TX_W-1:0] key_ext;
    logic [TX_W-1:0] adc_ext;

    // Widen both parallel sources to the shift register width.
    always_comb begin
        key_ext = '0;
        adc_ext = '0;
        key_ext[KEY_W-1:0] = key_word;
        adc_ext[ADC_W-1:0] = adc_word;
    end

    // Remember a pending read until the next select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            armed_adc <= 1'b0;
        end else if (arm) begin
            armed     <= 1'b1;
            armed_adc <= arm_adc;
        end else if (cs_rise) begin
            armed     <= 1'b0;
        end
    end

    // Output enable spans the read cycle's select-high window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe <= 1'b0;
        else if (cs_fall)
            oe <= 1'b0;
        else if (cs_rise && armed)
            oe <= 1'b1;
    end

    // Capture at the read cycle's start, then shift one bit per edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (cs_rise && armed)
            shreg <= armed_adc ? adc_ext : key_ext;
        else if (oe && shift_en)
            shreg <= {1'b0, shreg[TX_W-1:1]};
    end

    assign sdo = shreg[0];

    // R7: the output enable drops on the cycle after select release.
    a_r7_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !oe);

    // R10: while driving, the word moves only on a serial edge.
    a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !shift_en && !cs_rise) |=> $stable(shreg));
endmodule

// File: rtl/vfd_host_port.sv
// Top of the serial display command and readback port. It detects the
// select and serial-clock edges against one-cycle-old copies, feeds the
// receive register, decodes frames on select release and runs the
// readback shifter. Assumes csel, sclk and sdi are already synchronous.
module vfd_host_port
    import vfd_port_pkg::*;
#(
    parameter int SEG_W = 27,
    parameter int DIM_W = 10,
    parameter int KEY_W = 29,
    parameter int ADC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csel,
    input  logic             sclk,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_oe,
    output logic [SEG_W-1:0] seg_grid1,
    output logic [SEG_W-1:0] seg_grid2,
    output logic [SEG_W-1:0] seg_grid3,
    output logic [DIM_W-1:0] dim_level,
    input  logic [KEY_W-1:0] key_word,
    input  logic [ADC_W-1:0] adc_word,
    output logic             scan_stop
);
    localparam int RX_W = SEG_W + MODE_W;

    logic                        cs_q;
    logic                        sclk_q;
    logic                        cs_rise;
    logic                        cs_fall;
    logic                        bit_edge;
    logic                        rx_en;
    logic                        load;
    logic                        rd_arm;
    logic                        rd_adc;
    logic [RX_W-1:0]             rx_frame;
    logic [GRIDS-1:0][SEG_W-1:0] grid_q;

    // Keep one-cycle-old copies of select and serial clock for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= csel;
            sclk_q <= sclk;
        end
    end

    assign cs_rise  = csel & ~cs_q;
    assign cs_fall  = ~csel & cs_q;
    assign bit_edge = sclk & ~sclk_q & csel;
    assign rx_en    = bit_edge & ~sdo_oe;
    assign load     = cs_fall & ~sdo_oe;

    vfd_rx_shift #(.RX_W(RX_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rx_en),
        .din      (sdi),
        .frame    (rx_frame)
    );

    vfd_latch_bank #(.SEG_W(SEG_W), .DIM_W(DIM_W), .RX_W(RX_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .frame  (rx_frame),
        .grid_q (grid_q),
        .dim_q  (dim_level),
        .stop_q (scan_stop),
        .rd_arm (rd_arm),
        .rd_adc (rd_adc)
    );

    vfd_tx_shift #(.KEY_W(KEY_W), .ADC_W(ADC_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (rd_arm),
        .arm_adc  (rd_adc),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .shift_en (bit_edge),
        .key_word (key_word),
        .adc_word (adc_word),
        .sdo      (sdo),
        .oe       (sdo_oe)
    );

    assign seg_grid1 = grid_q[0];
    assign seg_grid2 = grid_q[1];
    assign seg_grid3 = grid_q[2];

    // R2: nothing enters the receive register while select is low.
    a_r2_cs_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !csel |=> $stable(rx_frame));

    // R7: the receive register is frozen while the port drives the line.
    a_r7_no_rx_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |=> $stable(rx_frame));

    // R7: the output is never enabled past a low select.
    a_r7_oe_only_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !csel |=> !sdo_oe);
endmodule

// File: tb/tb_vfd_host_port.sv
// Self-checking bench: sweeps all mode codes over several patterns and
// walks one-hot words through both read paths.
module tb_vfd_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csel = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        sdo_oe;
    logic [26:0] seg_grid1, seg_grid2, seg_grid3;
    logic [9:0]  dim_level;
    logic [28:0] key_word = '0;
    logic [47:0] adc_word = '0;
    logic        scan_stop;

    int errors = 0;
    int checks = 0;
    int stop_cnt = 0;
    logic [26:0] e_g1 = '0, e_g2 = '0, e_g3 = '0;
    logic [9:0]  e_dim = '0;

    always #4 clk = ~clk;

    vfd_host_port dut (
        .clk(clk), .rst_n(rst_n), .csel(csel), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .seg_grid1(seg_grid1),
        .seg_grid2(seg_grid2), .seg_grid3(seg_grid3), .dim_level(dim_level),
        .key_word(key_word), .adc_word(adc_word), .scan_stop(scan_stop)
    );

    always @(posedge clk) if (scan_stop) stop_cnt <= stop_cnt + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_sclk();
        sclk = 1'b1; tick(2);
        sclk = 1'b0; tick(2);
    endtask

    task automatic shift_bits(input logic [47:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sdi = v[i]; tick(1);
            pulse_sclk();
        end
    endtask

    task automatic write_frame(input logic [26:0] pay, input int n, input int mode);
        csel = 1'b1; tick(2);
        shift_bits({21'd0, pay}, n);
        shift_bits(48'(mode), 3);
        csel = 1'b0; tick(3);
    endtask

    // Read cycle: flips the parallel inputs after capture (R10).
    task automatic read_word(output logic [47:0] w, input int n);
        w = '0;
        csel = 1'b1; tick(3);
        check("R7 oe during read cycle", 64'(sdo_oe), 64'd1);
        key_word = ~key_word;
        adc_word = ~adc_word;
        for (int i = 0; i < n; i++) begin
            w[i] = sdo;
            pulse_sclk();
        end
        csel = 1'b0; tick(3);
        check("R7 oe after read cycle", 64'(sdo_oe), 64'd0);
    endtask

    task automatic check_latches(input string tag);
        check({tag, " grid1"}, 64'(seg_grid1), 64'(e_g1));
        check({tag, " grid2"}, 64'(seg_grid2), 64'(e_g2));
        check({tag, " grid3"}, 64'(seg_grid3), 64'(e_g3));
        check({tag, " dim"},   64'(dim_level), 64'(e_dim));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R1..R11 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [47:0] w;
        logic [26:0] p;
        int s0;
        tick(4); rst_n = 1'b1; tick(2);

        // R1 reset state
        check_latches("R1 reset");
        check("R1 sdo_oe", 64'(sdo_oe), 64'd0);
        check("R1 sdo", 64'(sdo), 64'd0);
        check("R1 scan_stop", 64'(scan_stop), 64'd0);

        // Sweep every mode over several payload patterns (R3..R7)
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 8; m++) begin
                case (k)
                    0: p = 27'h0000001 << m;
                    1: p = 27'h5555555;
                    2: p = 27'h7FFFFFF;
                    default: p = 27'(32'h2F1A7C3 * (m + 3) ^ 32'h0B6D19);
                endcase
                s0 = stop_cnt;
                if (m == 4) begin
                    write_frame(p, 10, m);
                    e_dim = p[9:0];
                    check_latches("R5 dimming frame");
                end else if (m == 5) begin
                    write_frame(p, 0, m);
                    check("R6 stop strobe count", 64'(stop_cnt - s0), 64'd1);
                    check_latches("R6 stop frame");
                end else if (m >= 6) begin
                    write_frame(p, 27, m);
                    check_latches("R7 read frame");
                    check("R7 oe before read cycle", 64'(sdo_oe), 64'd0);
                    key_word = p[26:0] + 29'h1000_0000;
                    adc_word = {p[23:0], p[26:3]};
                    w = (m == 6) ? {19'd0, key_word} : adc_word;
                    begin
                        logic [47:0] got;
                        read_word(got, (m == 6) ? 32 : 48);
                        check(m == 6 ? "R8 key read sweep" : "R9 adc read sweep", 64'(got), 64'(w));
                    end
                end else begin
                    write_frame(p, 27, m);
                    if (m == 0 || m == 1) e_g1 = p;
                    if (m == 0 || m == 2) e_g2 = p;
                    if (m == 0 || m == 3) e_g3 = p;
                    check_latches(m == 0 ? "R3 broadcast" : "R4 single grid");
                end
            end
        end

        // R8: one-hot key words expose every bit position
        for (int b = 0; b < 29; b++) begin
            write_frame(27'd0, 0, 6);
            key_word = 29'd1 << b;
            read_word(w, 29);
            check("R8 one-hot key position", 64'(w), 64'(48'd1 << b));
        end

        // R9: distinct channel values, channel k at bits 8(k-1)..8k-1
        adc_word = '0;
        for (int c = 0; c < 6; c++) adc_word[c*8 +: 8] = 8'(c * 37 + 5);
        w = adc_word;
        write_frame(27'd0, 0, 7);
        begin
            logic [47:0] got;
            read_word(got, 48);
            check("R9 adc channel order", 64'(got), 64'(w));
        end

        // R11: first bit before any clock, zeros past the word end
        write_frame(27'd0, 0, 6);
        key_word = 29'h1FFFFFFF;
        begin
            logic [47:0] got;
            read_word(got, 40);
            check("R11 zero fill after key word", 64'(got), 64'(48'h1FFFFFFF));
        end

        // R2: clocks while select is low must not alter the stored frame
        e_g1 = 27'h3C3C3C3;
        write_frame(e_g1, 27, 1);
        sdi = 1'b0; tick(1); pulse_sclk();
        sdi = 1'b1; tick(1); pulse_sclk();
        sdi = 1'b0; tick(1); pulse_sclk();
        csel = 1'b1; tick(3); csel = 1'b0; tick(3);
        check_latches("R2 cs-low clocks ignored");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule